// File: doc/BRIEF.md
# Fragment Reassembling Receive Engine

The block drives the host side of a message receive from a word-wide inbound mailbox. A caller starts it with the number of bytes its buffer can hold. The engine then takes in fragments one after another. For each fragment it pops a header slot and checks the fragment length against the space left. It waits until the whole payload is present in the mailbox, then pops the payload slots and streams the bytes out on a byte-wide interface. It ends with a done pulse that carries a pass or fail flag and the total number of bytes stored.

Each fragment header holds a 9-bit byte length and a completion flag. A fragment without the flag means more fragments follow. If the mailbox is empty at that point, the engine pulses an interrupt request so that the peer sends the next part. The engine does not start on a fragment until the peer reports ready. If the peer stays not-ready, the engine retries over several time windows before it gives up. The peer's ready is checked again after the whole words of each fragment. If ready has dropped, the trailing partial word is not taken and the receive fails.

Top module: `rx_reasm_seq`

## Requirements
- R1: After reset, and whenever `busy_o` is low, the engine pops no slot and strobes no byte. `done_o`, `ping_o` and `warn_o` stay low until a receive is started.
- R2: A header is popped only when `filled_i` is at least 1. The header's fragment length is bits 24:16, its completion flag is bit 31, and bits 15:0 and 30:25 have no effect.
- R3: A fragment whose length is greater than the remaining buffer space ends the receive with `done_o` high and `ok_o` low. No payload slot of that fragment is popped and no byte of it is output.
- R4: After the header, the engine pops no payload slot until `filled_i` is at least ceil(length/4). A slot is never popped while `filled_i` is 0.
- R5: Each payload slot is output little-endian, one byte per cycle with `byte_valid_o` high, so bits 7:0 come first. A trailing partial word is popped as one full slot, and only its length mod 4 low-order bytes are output.
- R6: After the whole words of a fragment, `peer_ready_i` is sampled. If it is low, the receive fails and the trailing partial slot is not popped.
- R7: At the end of a fragment without the completion flag, `ping_o` pulses for one cycle if and only if `filled_i` is 0.
- R8: A fragment of length 0 pulses `warn_o` for one cycle, and the receive fails on the next cycle.
- R9: A fragment with the completion flag ends the receive with a one-cycle `done_o`, with `ok_o` high and `total_o` equal to the sum of all fragment lengths.
- R10: If the buffer space reaches zero after a fragment without the completion flag, the receive fails.
- R11: Before the first header, the engine waits for `peer_ready_i` for up to `ATTEMPTS` windows of `READY_TMO` cycles each. It proceeds as soon as ready is seen, and fails once all windows have expired.
- R12: If a header or payload wait lasts `SLOT_TMO` cycles without enough filled slots, the receive fails.
- R13: A start with `buf_len_i` equal to 0 fails at once: `done_o` is high with `ok_o` low on the cycle after the start.
- R14: `start_i` has no effect while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a receive (taken only when idle) |
| buf_len_i | input | BUF_W | Caller buffer size in bytes |
| peer_ready_i | input | 1 | Peer ready status |
| filled_i | input | CNT_W | Number of filled inbound slots |
| slot_data_i | input | SLOT_W | Head slot of the inbound mailbox |
| slot_rd_o | output | 1 | Pop the head slot at this edge |
| byte_o | output | 8 | Reassembled byte |
| byte_valid_o | output | 1 | `byte_o` is valid |
| ping_o | output | 1 | Interrupt request to the peer for more data |
| warn_o | output | 1 | Zero-length fragment seen |
| busy_o | output | 1 | Receive in progress |
| done_o | output | 1 | Receive finished (one cycle) |
| ok_o | output | 1 | Receive succeeded; valid with `done_o` |
| total_o | output | BUF_W | Bytes stored; meaningful when `ok_o` is high |

## Verification
The assertions check on every cycle that a slot is never popped from an empty mailbox and that no byte or pop occurs while idle. They also check that ping, warn and done are single-cycle pulses, that a warning is always followed by a failing done, that a ping only happens with an empty mailbox, and that a success never reports zero bytes. The bench scenarios cover what only a full transfer can show. These are the little-endian byte order, the trimming of a partial word, the holding back of payload until enough slots have arrived, and the length-versus-space rejection. The scenarios also cover the ready drop before a trailing word, the retry windows on a slow peer, and the total reported over several fragments.

// File: rtl/rx_reasm_pkg.sv
package rx_reasm_pkg;
  localparam int unsigned HDR_LEN_LSB  = 16;
  localparam int unsigned HDR_LEN_W    = 9;
  localparam int unsigned HDR_LAST_BIT = 31;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RDY,
    ST_HDR_WAIT,
    ST_HDR_RD,
    ST_BODY_WAIT,
    ST_WORD_RD,
    ST_WORD_UNP,
    ST_CHECK,
    ST_TAIL_RD,
    ST_TAIL_UNP,
    ST_FRAG_END,
    ST_DONE
  } rx_state_e;
endpackage

// File: rtl/rx_hdr_decode.sv
module rx_hdr_decode
  import rx_reasm_pkg::*;
#(
  parameter int unsigned SLOT_W = 32,
  parameter int unsigned CNT_W  = 8,
  localparam int unsigned BPS   = SLOT_W / 8,
  localparam int unsigned OFF_W = $clog2(BPS)
) (
  input  logic [SLOT_W-1:0]    hdr_i,
  output logic [HDR_LEN_W-1:0] len_o,
  output logic                 last_o,
  output logic [CNT_W-1:0]     slots_o,
  output logic [HDR_LEN_W-1:0] whole_o,
  output logic [OFF_W-1:0]     rem_o
);
  logic [HDR_LEN_W:0] len_up;
  logic               unused_hdr;

  assign len_o   = hdr_i[HDR_LEN_LSB +: HDR_LEN_W];
  assign last_o  = hdr_i[HDR_LAST_BIT];
  assign len_up  = {1'b0, len_o} + (HDR_LEN_W+1)'(BPS - 1);
  assign slots_o = CNT_W'(len_up >> OFF_W);
  assign whole_o = len_o >> OFF_W;
  assign rem_o   = len_o[OFF_W-1:0];

  // routing and reserved fields are not used on receive
  assign unused_hdr = ^{hdr_i[HDR_LEN_LSB-1:0],
                        hdr_i[HDR_LAST_BIT-1:HDR_LEN_LSB+HDR_LEN_W]};
endmodule

// File: rtl/rx_wait_timer.sv
module rx_wait_timer #(
  parameter int unsigned LIMIT = 1000,
  localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic expired_o
);
  logic [CW-1:0] cnt_q;

  assign expired_o = en_i && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i || expired_o) cnt_q <= '0;
    else if (en_i)               cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rx_unpacker.sv
module rx_unpacker #(
  parameter int unsigned SLOT_W = 32,
  localparam int unsigned BPS   = SLOT_W / 8,
  localparam int unsigned NB_W  = $clog2(BPS) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [SLOT_W-1:0] word_i,
  input  logic [NB_W-1:0]   nbytes_i,
  output logic [7:0]        byte_o,
  output logic              valid_o,
  output logic              last_o
);
  logic [SLOT_W-1:0] word_q;
  logic [NB_W-1:0]   cnt_q;

  assign byte_o  = word_q[7:0];
  assign valid_o = (cnt_q != '0);
  assign last_o  = (cnt_q == NB_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      word_q <= word_i;
      cnt_q  <= nbytes_i;
    end else if (valid_o) begin
      word_q <= word_q >> 8;
      cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/rx_reasm_seq.sv
module rx_reasm_seq
  import rx_reasm_pkg::*;
#(
  parameter int unsigned SLOT_W    = 32,
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned BUF_W     = 16,
  parameter int unsigned READY_TMO = 1000,
  parameter int unsigned SLOT_TMO  = 1000,
  parameter int unsigned ATTEMPTS  = 5,
  localparam int unsigned BPS      = SLOT_W / 8,
  localparam int unsigned OFF_W    = $clog2(BPS),
  localparam int unsigned NB_W     = OFF_W + 1,
  localparam int unsigned ATT_W    = $clog2(ATTEMPTS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [BUF_W-1:0]  buf_len_i,
  input  logic              peer_ready_i,
  input  logic [CNT_W-1:0]  filled_i,
  input  logic [SLOT_W-1:0] slot_data_i,
  output logic              slot_rd_o,
  output logic [7:0]        byte_o,
  output logic              byte_valid_o,
  output logic              ping_o,
  output logic              warn_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              ok_o,
  output logic [BUF_W-1:0]  total_o
);
  rx_state_e state_q, state_d;
  logic [BUF_W-1:0]     left_q, left_d, total_q, total_d;
  logic [ATT_W-1:0]     att_q, att_d;
  logic [CNT_W-1:0]     slots_q, slots_d;
  logic [HDR_LEN_W-1:0] whole_q, whole_d;
  logic [OFF_W-1:0]     rem_q, rem_d;
  logic                 last_q, last_d, ok_q, ok_d;

  logic [HDR_LEN_W-1:0] hd_len, hd_whole;
  logic [CNT_W-1:0]     hd_slots;
  logic [OFF_W-1:0]     hd_rem;
  logic                 hd_last;

  logic rdy_exp, slot_exp, slot_wait, tmr_clr;
  logic unp_load, unp_last;
  logic [NB_W-1:0] unp_nbytes;

  rx_hdr_decode #(.SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_hdr (
    .hdr_i  (slot_data_i),
    .len_o  (hd_len),
    .last_o (hd_last),
    .slots_o(hd_slots),
    .whole_o(hd_whole),
    .rem_o  (hd_rem)
  );

  assign tmr_clr   = (state_d != state_q);
  assign slot_wait = (state_q == ST_HDR_WAIT) || (state_q == ST_BODY_WAIT);

  rx_wait_timer #(.LIMIT(READY_TMO)) u_rdy_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (tmr_clr),
    .en_i     (state_q == ST_RDY),
    .expired_o(rdy_exp)
  );

  rx_wait_timer #(.LIMIT(SLOT_TMO)) u_slot_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (tmr_clr),
    .en_i     (slot_wait),
    .expired_o(slot_exp)
  );

  rx_unpacker #(.SLOT_W(SLOT_W)) u_unp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (unp_load),
    .word_i  (slot_data_i),
    .nbytes_i(unp_nbytes),
    .byte_o  (byte_o),
    .valid_o (byte_valid_o),
    .last_o  (unp_last)
  );

  always_comb begin
    state_d    = state_q;
    left_d     = left_q;
    total_d    = total_q;
    att_d      = att_q;
    slots_d    = slots_q;
    whole_d    = whole_q;
    rem_d      = rem_q;
    last_d     = last_q;
    ok_d       = ok_q;
    slot_rd_o  = 1'b0;
    unp_load   = 1'b0;
    unp_nbytes = NB_W'(BPS);
    ping_o     = 1'b0;
    warn_o     = 1'b0;

    unique case (state_q)
      ST_IDLE: if (start_i) begin
        left_d  = buf_len_i;
        total_d = '0;
        att_d   = '0;
        if (buf_len_i == '0) begin
          ok_d    = 1'b0;
          state_d = ST_DONE;
        end else begin
          state_d = ST_RDY;
        end
      end
      ST_RDY: begin
        if (peer_ready_i) state_d = ST_HDR_WAIT;
        else if (rdy_exp) begin
          if (att_q == ATT_W'(ATTEMPTS - 1)) begin
            ok_d    = 1'b0;
            state_d = ST_DONE;
          end else begin
            att_d = att_q + 1'b1;
          end
        end
      end
      ST_HDR_WAIT: begin
        if (filled_i != '0) state_d = ST_HDR_RD;
        else if (slot_exp) begin
          ok_d    = 1'b0;
          state_d = ST_DONE;
        end
      end
      ST_HDR_RD: begin
        slot_rd_o = 1'b1;
        slots_d   = hd_slots;
        whole_d   = hd_whole;
        rem_d     = hd_rem;
        last_d    = hd_last;
        if (hd_len == '0) begin
          warn_o  = 1'b1;
          ok_d    = 1'b0;
          state_d = ST_DONE;
        end else if (BUF_W'(hd_len) > left_q) begin
          ok_d    = 1'b0;
          state_d = ST_DONE;
        end else begin
          left_d  = left_q - BUF_W'(hd_len);
          total_d = total_q + BUF_W'(hd_len);
          state_d = ST_BODY_WAIT;
        end
      end
      ST_BODY_WAIT: begin
        if (filled_i >= slots_q)
          state_d = (whole_q != '0) ? ST_WORD_RD : ST_CHECK;
        else if (slot_exp) begin
          ok_d    = 1'b0;
          state_d = ST_DONE;
        end
      end
      ST_WORD_RD: begin
        slot_rd_o = 1'b1;
        unp_load  = 1'b1;
        whole_d   = whole_q - 1'b1;
        state_d   = ST_WORD_UNP;
      end
      ST_WORD_UNP: if (unp_last)
        state_d = (whole_q != '0) ? ST_WORD_RD : ST_CHECK;
      ST_CHECK: begin
        if (!peer_ready_i) begin
          ok_d    = 1'b0;
          state_d = ST_DONE;
        end else begin
          state_d = (rem_q != '0) ? ST_TAIL_RD : ST_FRAG_END;
        end
      end
      ST_TAIL_RD: begin
        slot_rd_o  = 1'b1;
        unp_load   = 1'b1;
        unp_nbytes = NB_W'(rem_q);
        state_d    = ST_TAIL_UNP;
      end
      ST_TAIL_UNP: if (unp_last) state_d = ST_FRAG_END;
      ST_FRAG_END: begin
        if (last_q) begin
          ok_d    = 1'b1;
          state_d = ST_DONE;
        end else begin
          ping_o = (filled_i == '0);
          if (left_q == '0) begin
            ok_d    = 1'b0;
            state_d = ST_DONE;
          end else begin
            state_d = ST_HDR_WAIT;
          end
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      total_q <= '0;
      att_q   <= '0;
      slots_q <= '0;
      whole_q <= '0;
      rem_q   <= '0;
      last_q  <= 1'b0;
      ok_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      left_q  <= left_d;
      total_q <= total_d;
      att_q   <= att_d;
      slots_q <= slots_d;
      whole_q <= whole_d;
      rem_q   <= rem_d;
      last_q  <= last_d;
      ok_q    <= ok_d;
    end
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = (state_q == ST_DONE);
  assign ok_o    = ok_q;
  assign total_o = total_q;
endmodule

// File: rtl/rx_reasm_chk.sv
module rx_reasm_chk #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned BUF_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [BUF_W-1:0] buf_len_i,
  input logic [CNT_W-1:0] filled_i,
  input logic             slot_rd_o,
  input logic             byte_valid_o,
  input logic             ping_o,
  input logic             warn_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             ok_o,
  input logic [BUF_W-1:0] total_o
);
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!slot_rd_o && !byte_valid_o));                       // R1
  AST_POP_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_rd_o |-> (filled_i != '0));                                   // R4
  AST_BYTES_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |-> busy_o);                                          // R5
  AST_PING_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ping_o |=> !ping_o);                                               // R7
  AST_PING_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ping_o |-> (filled_i == '0));                                      // R7
  AST_WARN_FAILS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warn_o |=> (done_o && !ok_o));                                     // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);                                               // R9
  AST_OK_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ok_o) |-> (total_o != '0));                             // R9
  AST_ZERO_BUF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && buf_len_i == '0) |=> (done_o && !ok_o));   // R13
endmodule

bind rx_reasm_seq rx_reasm_chk #(.CNT_W(CNT_W), .BUF_W(BUF_W)) i_rx_reasm_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .buf_len_i   (buf_len_i),
  .filled_i    (filled_i),
  .slot_rd_o   (slot_rd_o),
  .byte_valid_o(byte_valid_o),
  .ping_o      (ping_o),
  .warn_o      (warn_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .ok_o        (ok_o),
  .total_o     (total_o)
);

// File: tb/test_rx_reasm_seq.sv
module test_rx_reasm_seq;
  localparam int unsigned SLOT_W    = 32;
  localparam int unsigned CNT_W     = 8;
  localparam int unsigned BUF_W     = 16;
  localparam int unsigned READY_TMO = 20;
  localparam int unsigned SLOT_TMO  = 200;
  localparam int unsigned ATTEMPTS  = 5;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic [BUF_W-1:0]  buf_len_i = '0;
  logic              peer_ready_i = 1'b1;
  logic [CNT_W-1:0]  filled_i = '0;
  logic [SLOT_W-1:0] slot_data_i = '0;
  logic              slot_rd_o, byte_valid_o, ping_o, warn_o, busy_o, done_o, ok_o;
  logic [7:0]        byte_o;
  logic [BUF_W-1:0]  total_o;

  always #5 clk_i = ~clk_i;

  rx_reasm_seq #(
    .SLOT_W(SLOT_W), .CNT_W(CNT_W), .BUF_W(BUF_W),
    .READY_TMO(READY_TMO), .SLOT_TMO(SLOT_TMO), .ATTEMPTS(ATTEMPTS)
  ) i_rx_reasm_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .buf_len_i(buf_len_i),
    .peer_ready_i(peer_ready_i), .filled_i(filled_i), .slot_data_i(slot_data_i),
    .slot_rd_o(slot_rd_o), .byte_o(byte_o), .byte_valid_o(byte_valid_o),
    .ping_o(ping_o), .warn_o(warn_o), .busy_o(busy_o), .done_o(done_o),
    .ok_o(ok_o), .total_o(total_o)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [31:0] mbox[$];
  logic [7:0]  rx_bytes[$];
  logic pop_pend = 1'b0;
  int ping_cnt, warn_cnt, done_cyc, start_cyc;
  logic done_seen, done_ok;
  logic [BUF_W-1:0] done_total;

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    pop_pend <= slot_rd_o;
  end

  // monitor and mailbox model, away from the active edge
  always @(negedge clk_i) begin
    if (byte_valid_o) rx_bytes.push_back(byte_o);
    if (ping_o) ping_cnt++;
    if (warn_o) warn_cnt++;
    if (done_o) begin
      done_seen  = 1'b1;
      done_ok    = ok_o;
      done_total = total_o;
      done_cyc   = cyc;
    end
    if (pop_pend && mbox.size() > 0) void'(mbox.pop_front());
    filled_i    = CNT_W'(mbox.size());
    slot_data_i = (mbox.size() > 0) ? mbox[0] : '0;
  end

  task automatic chk(input bit cond, input string tag, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] hdr(input int len, input bit last);
    return {last, 6'b0, 9'(len), 16'hA55A};
  endfunction

  task automatic push_body(input int len, input int base);
    for (int w = 0; w < (len + 3) / 4; w++) begin
      logic [31:0] word;
      for (int b = 0; b < 4; b++) word[8*b +: 8] = 8'(base + 4*w + b);
      mbox.push_back(word);
    end
  endtask

  task automatic push_frag(input int len, input bit last, input int base);
    mbox.push_back(hdr(len, last));
    push_body(len, base);
  endtask

  task automatic clear_mon();
    @(negedge clk_i);
    rx_bytes.delete();
    mbox.delete();
    ping_cnt = 0; warn_cnt = 0;
    done_seen = 1'b0; done_ok = 1'b0; done_total = '0;
  endtask

  task automatic start(input int blen);
    @(negedge clk_i);
    start_i = 1'b1; buf_len_i = BUF_W'(blen);
    start_cyc = cyc;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic wait_done(input int limit);
    for (int i = 0; i < limit && !done_seen; i++) @(negedge clk_i);
    repeat (2) @(negedge clk_i);
  endtask

  task automatic chk_bytes(input int n, input int base, input string tag);
    bit good = (rx_bytes.size() == n);
    int bad = -1;
    chk(good, {tag, " byte count"}, rx_bytes.size(), n);
    for (int i = 0; i < rx_bytes.size() && i < n; i++)
      if (rx_bytes[i] != 8'(base + i) && bad < 0) bad = i;
    chk(bad < 0, {tag, " byte order (first bad index)"}, bad, -1);
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    chk(!busy_o && !done_o && !ping_o && !warn_o && !slot_rd_o && !byte_valid_o,
        "R1 reset quiet", {busy_o, done_o, ping_o, warn_o, slot_rd_o, byte_valid_o}, 0);
  endtask

  task automatic t_single();
    clear_mon();
    push_frag(6, 1'b1, 8'h10);
    start(64);
    wait_done(500);
    chk(done_seen && done_ok, "R9 single ok", done_ok, 1);
    chk(done_total == 6, "R9 single total", done_total, 6);
    chk_bytes(6, 8'h10, "R5 R2 single");
    chk(mbox.size() == 0, "R5 partial slot popped", mbox.size(), 0);
    chk(ping_cnt == 0, "R7 no ping when complete", ping_cnt, 0);
  endtask

  task automatic t_multi_queued();
    clear_mon();
    push_frag(8, 1'b0, 8'h40);
    push_frag(3, 1'b1, 8'h48);
    start(100);
    wait_done(500);
    chk(done_ok && done_total == 11, "R9 two fragments total", done_total, 11);
    chk_bytes(11, 8'h40, "R5 two fragments");
    chk(ping_cnt == 0, "R7 no ping while slots filled", ping_cnt, 0);
  endtask

  task automatic t_ping();
    clear_mon();
    push_frag(4, 1'b0, 8'h60);
    start(100);
    for (int i = 0; i < 300 && ping_cnt == 0; i++) @(negedge clk_i);
    chk(ping_cnt == 1, "R7 ping on empty after incomplete", ping_cnt, 1);
    push_frag(2, 1'b1, 8'h64);
    wait_done(500);
    chk(done_ok && done_total == 6, "R7 R9 resumed total", done_total, 6);
    chk_bytes(6, 8'h60, "R7 resumed");
  endtask

  task automatic t_too_big();
    clear_mon();
    push_frag(8, 1'b1, 8'h00);
    start(4);
    wait_done(500);
    chk(done_seen && !done_ok, "R3 oversize fails", done_ok, 0);
    chk(rx_bytes.size() == 0, "R3 no bytes", rx_bytes.size(), 0);
    chk(mbox.size() == 2, "R3 payload left in mailbox", mbox.size(), 2);
  endtask

  task automatic t_slot_hold();
    clear_mon();
    mbox.push_back(hdr(7, 1'b1));
    push_body(4, 8'h20);
    start(50);
    repeat (40) @(negedge clk_i);
    chk(rx_bytes.size() == 0 && mbox.size() == 1, "R4 payload held until 2 slots",
        mbox.size(), 1);
    begin
      logic [31:0] w2 = {8'h00, 8'h26, 8'h25, 8'h24};
      mbox.push_back(w2);
    end
    wait_done(500);
    chk(done_ok && done_total == 7, "R4 completes after arrival", done_total, 7);
    chk_bytes(7, 8'h20, "R4 R5 trimmed tail");
  endtask

  task automatic t_ready_drop();
    clear_mon();
    mbox.push_back(hdr(5, 1'b1));
    push_body(4, 8'h30);
    start(50);
    repeat (20) @(negedge clk_i);
    peer_ready_i = 1'b0;
    mbox.push_back(32'h0000_0034);
    wait_done(500);
    peer_ready_i = 1'b1;
    chk(done_seen && !done_ok, "R6 ready low before tail fails", done_ok, 0);
    chk(mbox.size() == 1, "R6 tail not popped", mbox.size(), 1);
    chk(rx_bytes.size() == 4, "R6 whole word delivered", rx_bytes.size(), 4);
  endtask

  task automatic t_zero_len();
    clear_mon();
    push_frag(0, 1'b1, 0);
    start(16);
    wait_done(500);
    chk(warn_cnt == 1, "R8 warn pulse", warn_cnt, 1);
    chk(done_seen && !done_ok, "R8 zero length fails", done_ok, 0);
  endtask

  task automatic t_exhaust();
    clear_mon();
    push_frag(4, 1'b0, 8'h70);
    start(4);
    wait_done(500);
    chk(done_seen && !done_ok, "R10 space exhausted fails", done_ok, 0);
    chk(rx_bytes.size() == 4, "R10 bytes before exhaust", rx_bytes.size(), 4);
  endtask

  task automatic t_attempts();
    clear_mon();
    peer_ready_i = 1'b0;
    push_frag(2, 1'b1, 8'h50);
    start(16);
    repeat (3 * READY_TMO + 5) @(negedge clk_i);
    chk(!done_seen && mbox.size() == 2, "R11 waits while not ready", mbox.size(), 2);
    peer_ready_i = 1'b1;
    wait_done(500);
    chk(done_ok && done_total == 2, "R11 late ready succeeds", done_total, 2);
    clear_mon();
    peer_ready_i = 1'b0;
    start(16);
    wait_done(2000);
    peer_ready_i = 1'b1;
    chk(done_seen && !done_ok, "R11 never ready fails", done_ok, 0);
    chk(done_cyc - start_cyc >= ATTEMPTS * READY_TMO, "R11 all windows used",
        done_cyc - start_cyc, ATTEMPTS * READY_TMO);
  endtask

  task automatic t_slot_timeout();
    clear_mon();
    start(16);
    wait_done(1000);
    chk(done_seen && !done_ok, "R12 header wait timeout fails", done_ok, 0);
    chk(done_cyc - start_cyc >= SLOT_TMO, "R12 timeout length",
        done_cyc - start_cyc, SLOT_TMO);
  endtask

  task automatic t_zero_buf();
    clear_mon();
    start(0);
    wait_done(20);
    chk(done_seen && !done_ok, "R13 zero buffer fails", done_ok, 0);
    chk(done_cyc - start_cyc <= 2, "R13 immediate", done_cyc - start_cyc, 2);
  endtask

  task automatic t_start_busy();
    clear_mon();
    start(16);
    repeat (5) @(negedge clk_i);
    start(0);
    repeat (5) @(negedge clk_i);
    chk(busy_o && !done_seen, "R14 start ignored when busy", done_seen, 0);
    push_frag(3, 1'b1, 8'h90);
    wait_done(500);
    chk(done_ok && done_total == 3, "R14 original receive finishes", done_total, 3);
    chk_bytes(3, 8'h90, "R14");
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog R1..all actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_single();
    t_multi_queued();
    t_ping();
    t_too_big();
    t_slot_hold();
    t_ready_drop();
    t_zero_len();
    t_exhaust();
    t_attempts();
    t_slot_timeout();
    t_zero_buf();
    t_start_busy();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule